// File: doc/BRIEF.md
# Multi-Mode Counter/Latch Timer

This block is a 16-bit down-counter paired with a 16-bit reload value register (the latch). It sits behind a small processor register bus and has one bidirectional counter pin, which it models as a separate input, output and output-enable. A two-bit mode field picks one of four uses for the shared counter:

- a free-running interval timer;
- a pulse generator that toggles the pin;
- an event counter that counts rising edges on the pin;
- a meter for the width of a low pulse on the pin.

When the counter passes below zero it reloads from the latch. The same event raises an overflow flag, and that flag can raise an interrupt request.

Software writes the latch one byte at a time. A write to the upper byte through the transfer address also presets the counter, so a new period can start at a known moment. The overflow flag is cleared by reading the low counter byte or by a preset. Each mode is meant to be used as follows:

- Pulse-generator mode makes square waves or one-shots on the pin.
- Event-counter mode counts external events.
- Pulse-width mode measures a low pulse: the counter is preset, the pin is let go low, and the counter is read back once the pin is high again.

The bus is a plain strobe interface with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high. A read's side effect happens on the edge where `bus_rd` is high. There is no valid/ready stream anywhere in this block.

Top module: `tmr_multimode`

## Requirements

- R1: While `rst_n` is low, and after it is released, the control register reads 0x00. This selects interval mode with the interrupt disabled and the overflow flag clear. The pin is driven high (`cpin_oe`=1, `cpin_o`=1) and `irq` is 0. Reset does not alter the latch or the counter, and bus reads made during reset have no side effect.
- R2: The register map, as byte addresses on `bus_addr`, is:
  - 0: control. Bit 7 is the overflow flag and is read-only. Bit 6 is the interrupt enable. Bits 1:0 are the mode. Bits 5:2 read 0.
  - 1: latch low byte, read/write.
  - 2: latch high byte, read/write, with no effect on the counter.
  - 3: write-only transfer. It writes the latch high byte and presets the counter.
  - 4: counter low byte, read.
  - 5: counter high byte, read.
  - Addresses 6 and 7 read 0x00.
- R3: A write of value D to address 3 loads the latch high byte with D. On the same edge it loads the counter with {D, latch low byte}. This preset takes priority over any decrement or reload on that edge.
- R4: In mode 00 (interval) and mode 01 (pulse generator) the counter decrements by one on every clock edge.
- R5: A decrement applied while the counter is 0x0000 is an underflow. The counter then loads the latch value and control bit 7 is set. With latch value L the underflow period is therefore L+1 counting steps.
- R6: In mode 00 the pin is driven high. In mode 01 the pin is driven and its level inverts on every underflow.
- R7: In mode 01 a write to address 3 also inverts the pin level. When that write coincides with an underflow, the pin inverts exactly once.
- R8: In mode 10 (event counter) the counter decrements once per rising edge seen on `cpin_i`. The input passes through two synchronizer flops and an edge detector. The decrement therefore lands on the third clock edge after the input rises. Alternating the input every clock (half the clock rate) still counts every rising edge.
- R9: In mode 11 (pulse width) the counter decrements on each clock while the synchronized pin is low, and holds while it is high. A low pulse lasting N clocks removes exactly N from the count.
- R10: The overflow flag is cleared by a read of address 4 and by a write to address 3. A read of address 5 or of address 0 leaves it set.
- R11: `irq` is high exactly while both the overflow flag and control bit 6 are set.
- R12: If an underflow falls on the same edge as a read of address 4, the overflow flag ends up set.
- R13: In modes 10 and 11 the pin is not driven (`cpin_oe`=0).

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register byte address |
| bus_rd | input | 1 | Read strobe (side effects on this edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| cpin_i | input | 1 | Counter pin input level |
| cpin_o | output | 1 | Counter pin output level |
| cpin_oe | output | 1 | Counter pin output enable |
| irq | output | 1 | Counter interrupt request |

## Verification

Two pairs of functions can land on the same clock edge, and both are tested.

The first pair is an underflow and a read of the low counter byte. The bench presets a short period and starts the read so that it spans exactly the edge where the counter passes zero. It then reads the control register and expects the overflow flag still set.

The second pair is an underflow and a transfer write in pulse-generator mode. The bench issues the transfer on the wrap edge. It then expects four things: the counter holds the preset value, the overflow flag is clear, the pin has inverted once and not twice, and counting goes on from the preset.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_PULSE    = 2'b01,
    MODE_EVENT    = 2'b10,
    MODE_WIDTH    = 2'b11
  } mmt_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] A_LAT_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LAT_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LAT_XFER = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 3'd5;

  localparam int CTRL_MODE_W = 2;

endpackage

// File: rtl/mmt_pin_sync.sv
module mmt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Idle level of the pin is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

  generate
    if (STAGES == 2) begin : g_chk2
      AST_RISE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> ($past(pin_i, 2) && !$past(pin_i, 3)))
        else $error("rise without matching input edge"); // R8
    end
  endgenerate

endmodule

// File: rtl/mmt_count_core.sv
module mmt_count_core #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_en,
  input  logic                  latch_lo_we,
  input  logic                  latch_hi_we,
  input  logic                  preset,
  input  logic                  clr_ovf,
  input  logic [DATA_W-1:0]     wdata,
  output logic [2*DATA_W-1:0]   cnt_o,
  output logic [2*DATA_W-1:0]   latch_o,
  output logic                  ovf_o,
  output logic                  underflow_o
);

  localparam int CW = 2 * DATA_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] latch_q;
  logic          ovf_q;
  logic          underflow;

  // A preset on the same edge pre-empts the wrap.
  assign underflow = dec_en & ~preset & (cnt_q == '0);

  // Latch and counter deliberately have no reset value; they freeze during reset.
  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (latch_lo_we)
        latch_q[DATA_W-1:0] <= wdata;
      if (latch_hi_we || preset)
        latch_q[CW-1:DATA_W] <= wdata;
      if (preset)
        cnt_q <= {wdata, latch_q[DATA_W-1:0]};
      else if (dec_en)
        cnt_q <= (cnt_q == '0) ? latch_q : (cnt_q - CW'(1));
    end
  end

  // Set wins over the read-clear; preset clears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else if (preset)
      ovf_q <= 1'b0;
    else if (underflow)
      ovf_q <= 1'b1;
    else if (clr_ovf)
      ovf_q <= 1'b0;
  end

  assign cnt_o       = cnt_q;
  assign latch_o     = latch_q;
  assign ovf_o       = ovf_q;
  assign underflow_o = underflow;

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (ovf_q && cnt_q == $past(latch_q)))
    else $error("wrap did not reload"); // R5

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (!ovf_q && cnt_q == {$past(wdata), $past(latch_q[DATA_W-1:0])}))
    else $error("preset value wrong"); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !preset) |=> $stable(cnt_q))
    else $error("counter moved without enable"); // R9

  AST_OVF_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_q) |-> $past(clr_ovf || preset))
    else $error("overflow cleared without cause"); // R10

endmodule

// File: rtl/mmt_bus_if.sv
module mmt_bus_if
  import mmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [2*DATA_W-1:0]   cnt,
  input  logic [2*DATA_W-1:0]   latch,
  input  logic                  ovf,
  output logic [DATA_W-1:0]     rdata,
  output mmt_mode_e             mode,
  output logic                  irq_en,
  output logic                  latch_lo_we,
  output logic                  latch_hi_we,
  output logic                  preset,
  output logic                  clr_ovf,
  output logic                  ctrl_we
);

  localparam int CW     = 2 * DATA_W;
  localparam int OVF_B  = DATA_W - 1;
  localparam int IE_B   = DATA_W - 2;

  mmt_mode_e         mode_q;
  logic              ie_q;
  logic [DATA_W-1:0] ctrl_rd;

  assign ctrl_we     = wr && (addr == A_CTRL);
  assign latch_lo_we = wr && (addr == A_LAT_LO);
  assign latch_hi_we = wr && (addr == A_LAT_HI);
  assign preset      = wr && (addr == A_LAT_XFER);
  assign clr_ovf     = rd && (addr == A_CNT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INTERVAL;
      ie_q   <= 1'b0;
    end else if (ctrl_we) begin
      mode_q <= mmt_mode_e'(wdata[CTRL_MODE_W-1:0]);
      ie_q   <= wdata[IE_B];
    end
  end

  always_comb begin
    ctrl_rd                    = '0;
    ctrl_rd[OVF_B]             = ovf;
    ctrl_rd[IE_B]              = ie_q;
    ctrl_rd[CTRL_MODE_W-1:0]   = mode_q;
  end

  always_comb begin
    unique case (addr)
      A_CTRL:   rdata = ctrl_rd;
      A_LAT_LO: rdata = latch[DATA_W-1:0];
      A_LAT_HI: rdata = latch[CW-1:DATA_W];
      A_CNT_LO: rdata = cnt[DATA_W-1:0];
      A_CNT_HI: rdata = cnt[CW-1:DATA_W];
      default:  rdata = '0;
    endcase
  end

  assign mode   = mode_q;
  assign irq_en = ie_q;

endmodule

// File: rtl/tmr_multimode.sv
module tmr_multimode
  import mmt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 cpin_i,
  output logic                 cpin_o,
  output logic                 cpin_oe,
  output logic                 irq
);

  localparam int CW = 2 * DATA_W;

  mmt_mode_e     mode;
  logic          irq_en;
  logic          latch_lo_we;
  logic          latch_hi_we;
  logic          preset;
  logic          clr_ovf;
  logic          ctrl_we;
  logic [CW-1:0] cnt;
  logic [CW-1:0] latch;
  logic          ovf;
  logic          underflow;
  logic          pin_level;
  logic          pin_rise;
  logic          dec_en;
  logic          pin_q;

  mmt_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (cpin_i),
    .level_o (pin_level),
    .rise_o  (pin_rise)
  );

  mmt_bus_if #(.DATA_W(DATA_W)) i_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (bus_addr),
    .rd          (bus_rd),
    .wr          (bus_wr),
    .wdata       (bus_wdata),
    .cnt         (cnt),
    .latch       (latch),
    .ovf         (ovf),
    .rdata       (bus_rdata),
    .mode        (mode),
    .irq_en      (irq_en),
    .latch_lo_we (latch_lo_we),
    .latch_hi_we (latch_hi_we),
    .preset      (preset),
    .clr_ovf     (clr_ovf),
    .ctrl_we     (ctrl_we)
  );

  always_comb begin
    unique case (mode)
      MODE_INTERVAL,
      MODE_PULSE:  dec_en = 1'b1;
      MODE_EVENT:  dec_en = pin_rise;
      MODE_WIDTH:  dec_en = ~pin_level;
      default:     dec_en = 1'b0;
    endcase
  end

  mmt_count_core #(.DATA_W(DATA_W)) i_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_en      (dec_en),
    .latch_lo_we (latch_lo_we),
    .latch_hi_we (latch_hi_we),
    .preset      (preset),
    .clr_ovf     (clr_ovf),
    .wdata       (bus_wdata),
    .cnt_o       (cnt),
    .latch_o     (latch),
    .ovf_o       (ovf),
    .underflow_o (underflow)
  );

  // Pin level: parked high in interval mode, inverts in pulse mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_q <= 1'b1;
    else if (mode == MODE_INTERVAL)
      pin_q <= 1'b1;
    else if ((mode == MODE_PULSE) && (underflow || preset))
      pin_q <= ~pin_q;
  end

  assign cpin_o  = (mode == MODE_INTERVAL) | pin_q;
  assign cpin_oe = (mode == MODE_INTERVAL) | (mode == MODE_PULSE);
  assign irq     = ovf & irq_en;

  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_PULSE) && (underflow || preset) && !ctrl_we) |=> (cpin_o != $past(cpin_o)))
    else $error("pulse pin did not invert"); // R6

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (preset && !ctrl_we) |=> !irq)
    else $error("irq after preset"); // R11

endmodule

// File: tb/test_tmr_multimode.sv
`timescale 1ns/1ps
module test_tmr_multimode;
  import mmt_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cpin_i;
  logic       cpin_o;
  logic       cpin_oe;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr_multimode i_tmr_multimode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpin_i    (cpin_i),
    .cpin_o    (cpin_o),
    .cpin_oe   (cpin_oe),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(req, {8'h00, bus_rdata}, {8'h00, exp});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // {is_read, addr[2:0], wdata[7:0], expect[7:0]} -- register map, R2/R3
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h03, 8'h00},  // mode 11, pin high: counter stopped
    {1'b0, 3'd1, 8'h34, 8'h00},
    {1'b0, 3'd2, 8'h12, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h34},
    {1'b1, 3'd2, 8'h00, 8'h12},
    {1'b0, 3'd3, 8'h56, 8'h00},  // R3 preset 0x5634
    {1'b1, 3'd0, 8'h00, 8'h03},
    {1'b1, 3'd4, 8'h00, 8'h34},
    {1'b1, 3'd5, 8'h00, 8'h56},
    {1'b1, 3'd2, 8'h00, 8'h56},
    {1'b0, 3'd1, 8'hAB, 8'h00},
    {1'b1, 3'd4, 8'h00, 8'h34},
    {1'b1, 3'd1, 8'h00, 8'hAB},
    {1'b0, 3'd0, 8'hFF, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h43},  // bit7 read-only, bits 5:2 read 0
    {1'b0, 3'd0, 8'h03, 8'h00},
    {1'b0, 3'd2, 8'h99, 8'h00},  // plain high-latch write: counter untouched
    {1'b1, 3'd5, 8'h00, 8'h56},
    {1'b1, 3'd2, 8'h00, 8'h99},
    {1'b1, 3'd6, 8'h00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpin_i = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {15'd0, cpin_oe}, 16'd1);
    chk("R1 pin", {15'd0, cpin_o}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd(VEC[i][18:16], VEC[i][7:0], "R2 map");
      else            wr(VEC[i][18:16], VEC[i][15:8]);
    end
    chk("R13 width oe", {15'd0, cpin_oe}, 16'd0);

    // R4 free-run decrement in interval mode
    wr(A_CTRL, 8'h40);
    wr(A_LAT_LO, 8'h00);
    wr(A_LAT_XFER, 8'h01);            // count 0x0100
    repeat (10) @(negedge clk);
    rd(A_CNT_LO, 8'hF6, "R4 lo");
    rd(A_CNT_HI, 8'h00, "R4 hi");

    // R5 wrap, R11 irq, R6 interval pin high
    wr(A_LAT_LO, 8'h05);
    wr(A_LAT_XFER, 8'h00);            // count 5
    repeat (5) @(negedge clk);
    chk("R11 irq low", {15'd0, irq}, 16'd0);
    rd(A_CTRL, 8'h40, "R5 before wrap");
    rd(A_CTRL, 8'hC0, "R5 after wrap");
    chk("R11 irq high", {15'd0, irq}, 16'd1);
    chk("R6 interval pin", {14'd0, cpin_oe, cpin_o}, 16'd3);

    // R12 read-clear coincides with wrap
    wr(A_LAT_LO, 8'h04);
    wr(A_LAT_XFER, 8'h00);
    chk("R10 preset clears", {15'd0, irq}, 16'd0);
    repeat (4) @(negedge clk);
    rd(A_CNT_LO, 8'h00, "R12 read at wrap");
    rd(A_CTRL, 8'hC0, "R12 flag kept");

    // R6/R7 pulse generator
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    wr(A_LAT_LO, 8'h03);
    wr(A_LAT_XFER, 8'h00);            // pin inverts to 0, count 3
    chk("R7 preset toggles", {14'd0, cpin_oe, cpin_o}, 16'd2);
    repeat (3) @(negedge clk);
    chk("R6 pin before wrap", {15'd0, cpin_o}, 16'd0);
    @(negedge clk);
    chk("R6 pin at wrap", {15'd0, cpin_o}, 16'd1);
    repeat (4) @(negedge clk);
    chk("R6 pin next wrap", {15'd0, cpin_o}, 16'd0);

    // R7/R12 preset coincides with wrap
    wr(A_LAT_LO, 8'h02);
    wr(A_LAT_XFER, 8'h00);            // pin -> 1, count 2
    repeat (2) @(negedge clk);
    wr(A_LAT_XFER, 8'h00);            // lands on the wrap edge
    chk("R7 single invert", {15'd0, cpin_o}, 16'd0);
    rd(A_CTRL, 8'h01, "R12 preset beats wrap");
    rd(A_CNT_LO, 8'h01, "R3 count after preset");

    // R8 event counter
    wr(A_CTRL, 8'h02);
    chk("R13 event oe", {15'd0, cpin_oe}, 16'd0);
    wr(A_LAT_LO, 8'h10);
    wr(A_LAT_XFER, 8'h00);
    for (int k = 0; k < 4; k++) begin
      cpin_i = 1'b0; repeat (2) @(negedge clk);
      cpin_i = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(A_CNT_LO, 8'h0C, "R8 slow edges");
    for (int k = 0; k < 4; k++) begin
      cpin_i = 1'b0; @(negedge clk);
      cpin_i = 1'b1; @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(A_CNT_LO, 8'h08, "R8 half-rate edges");

    // R9 pulse width
    wr(A_CTRL, 8'h03);
    wr(A_LAT_LO, 8'h00);
    wr(A_LAT_XFER, 8'h02);            // 0x0200
    cpin_i = 1'b0; repeat (7) @(negedge clk);
    cpin_i = 1'b1; repeat (6) @(negedge clk);
    rd(A_CNT_LO, 8'hF9, "R9 low width");
    rd(A_CNT_HI, 8'h01, "R9 high byte");
    repeat (20) @(negedge clk);
    rd(A_CNT_LO, 8'hF9, "R9 hold");

    // R10/R11 clear only by low-byte read
    wr(A_CTRL, 8'h40);
    wr(A_LAT_LO, 8'h03);
    wr(A_LAT_XFER, 8'h00);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 8'h43);                // stop with count 0, flag set
    rd(A_CTRL, 8'hC3, "R10 flag set");
    chk("R11 irq on", {15'd0, irq}, 16'd1);
    rd(A_CNT_HI, 8'h00, "R10 hi read");
    rd(A_CTRL, 8'hC3, "R10 hi keeps flag");
    rd(A_CNT_LO, 8'h00, "R10 lo read");
    rd(A_CTRL, 8'h43, "R10 lo clears flag");
    chk("R11 irq off", {15'd0, irq}, 16'd0);

    // R1 reset keeps latch and counter
    wr(A_LAT_LO, 8'h5A);
    rst_n = 1'b0;
    @(negedge clk);
    rd(A_CTRL, 8'h00, "R1 ctrl cleared");
    rd(A_LAT_LO, 8'h5A, "R1 latch kept");
    rd(A_CNT_LO, 8'h00, "R1 count kept");
    chk("R1 pin driven high", {14'd0, cpin_oe, cpin_o}, 16'd3);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule